// File: doc/BRIEF.md
# Splittable Four-Input Lookup Cell with Carry

This block is one logic element of a programmable fabric. A 16-bit truth table sets the function, and a 2-bit mode word sets how the table is used. The block has no clock. Four data lines and a carry input produce a 4-input result, a pair of 3-input results, two cell outputs and a carry output.

In single-function mode the whole table is one function of all four data lines. In split mode each 8-bit half of the table is its own 3-input function of the low three data lines. In this mode the top table input is held high, so the 4-input result follows the upper half.

In arithmetic mode the carry input replaces data line 2 as table input 2. The lower byte of the table holds two 2-input functions of data lines 0 and 1, propagate and generate, and these feed a 2:1 carry multiplexer. The upper byte holds the sum as a function of data lines 0 and 1 and the carry input. Cells placed side by side, each carry output wired to the next carry input, form a ripple adder.

Top module: `flut4_carry_cell`

## Requirements
- R1: Mode 2'b00: `lut4_o` equals `cfg_table[{din[3],din[2],din[1],din[0]}]`.
- R2: Mode 2'b10 is reserved and behaves exactly like mode 2'b00 on every output.
- R3: Mode 2'b01: `lut3_o[k]` equals `cfg_table[8*k + {din[2],din[1],din[0]}]` for k = 0 and 1.
- R4: Mode 2'b01: `lut4_o` equals `lut3_o[1]`, because the top table input is held at 1.
- R5: Mode 2'b11: `lut4_o` carries the sum `cfg_table[8 + {carry_i,din[1],din[0]}]`. `din[2]` and `din[3]` have no effect on any output.
- R6: Mode 2'b11: with propagate P = `cfg_table[{din[1],din[0]}]` and generate G = `cfg_table[4 + {din[1],din[0]}]`, `carry_o` is `carry_i` when P is 1 and G when P is 0.
- R7: In every mode other than 2'b11, `carry_o` is 0 and `carry_i` has no effect on any output.
- R8: `cell_o[0]` is `lut3_o[0]` in mode 2'b01 and `lut4_o` in every other mode. `cell_o[1]` always equals `lut3_o[1]`.
- R9: In modes 2'b00 and 2'b10, `lut3_o[k]` equals `cfg_table[8*k + {din[2],din[1],din[0]}]`. In mode 2'b11 the same holds with `carry_i` in place of `din[2]`.
- R10: Four cells, each loaded with table 16'h9686 in mode 2'b11 and chained carry to carry, add two 4-bit operands on `din[0]`/`din[1]` plus a carry-in. The sums appear on `lut4_o` and the final carry on the last `carry_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_table | input | 16 | Truth-table configuration bits |
| cfg_mode | input | 2 | Mode: 00 single, 01 split, 10 reserved, 11 arithmetic |
| din | input | 4 | Data inputs |
| carry_i | input | 1 | Carry input from the previous cell |
| lut4_o | output | 1 | 4-input result, or the sum in arithmetic mode |
| lut3_o | output | 2 | Lower-half and upper-half 3-input results |
| cell_o | output | 2 | Cell outputs after the output selector |
| carry_o | output | 1 | Carry output to the next cell |

## Verification
The hardest condition to reach is a carry that has to travel through every cell of a chain. That happens only when every cell propagates and the incoming carry is set, for example 0b1111 + 0b0000 + 1. A sweep of random operands seldom lands on it, so the chain stimulus runs through all 512 combinations of two 4-bit operands and the carry-in. Random tables in every mode, including the reserved code, check the table indexing. In the modes that must ignore them, the carry input and the upper data lines are driven at random, so any leak shows up as a miscompare.

// File: rtl/flut4_pkg.sv
package flut4_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_SPLIT  = 2'b01,
    MODE_RSVD   = 2'b10,
    MODE_ARITH  = 2'b11
  } flut_mode_e;
endpackage

// File: rtl/flut4_mux_tree.sv
module flut4_mux_tree #(
  parameter int SEL_W = 3,
  localparam int LEAVES = 2 ** SEL_W
) (
  input  logic [LEAVES-1:0] leaf_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              y_o
);
  // Level 0 holds the leaves; each level halves, steered by one select bit (LSB first).
  for (genvar l = 0; l <= SEL_W; l++) begin : g_lvl
    localparam int W = 2 ** (SEL_W - l);
    logic [W-1:0] v;
    if (l == 0) begin : g_leaf
      assign v = leaf_i;
    end else begin : g_node
      for (genvar n = 0; n < W; n++) begin : g_n
        assign v[n] = sel_i[l-1] ? g_lvl[l-1].v[2*n+1] : g_lvl[l-1].v[2*n];
      end
    end
  end
  assign y_o = g_lvl[SEL_W].v[0];
endmodule

// File: rtl/flut4_carry_mux.sv
module flut4_carry_mux (
  input  logic       enable_i,
  input  logic [3:0] prop_fn_i,
  input  logic [3:0] gen_fn_i,
  input  logic [1:0] sel_i,
  input  logic       carry_i,
  output logic       carry_o
);
  logic prop;
  logic gen;

  flut4_mux_tree #(.SEL_W(2)) i_prop (.leaf_i(prop_fn_i), .sel_i(sel_i), .y_o(prop));
  flut4_mux_tree #(.SEL_W(2)) i_gen  (.leaf_i(gen_fn_i),  .sel_i(sel_i), .y_o(gen));

  always_comb begin
    carry_o = 1'b0;
    if (enable_i) carry_o = prop ? carry_i : gen;
  end
endmodule

// File: rtl/flut4_carry_cell.sv
module flut4_carry_cell
  import flut4_pkg::*;
#(
  parameter int LUT_K = 4,
  localparam int TBL_W  = 2 ** LUT_K,
  localparam int HALF_W = TBL_W / 2
) (
  input  logic [TBL_W-1:0] cfg_table,
  input  logic [1:0]       cfg_mode,
  input  logic [LUT_K-1:0] din,
  input  logic             carry_i,
  output logic             lut4_o,
  output logic [1:0]       lut3_o,
  output logic [1:0]       cell_o,
  output logic             carry_o
);
  flut_mode_e        mode;
  logic              is_arith;
  logic              is_split;
  logic [LUT_K-2:0]  half_sel;
  logic              top_sel;
  logic              lo_res;
  logic              hi_res;

  assign mode     = flut_mode_e'(cfg_mode);
  assign is_arith = (mode == MODE_ARITH);
  assign is_split = (mode == MODE_SPLIT);

  // Input selector: table input 2 takes the chain carry in arithmetic mode.
  always_comb begin
    half_sel    = din[LUT_K-2:0];
    half_sel[2] = is_arith ? carry_i : din[2];
  end

  // The top table input is forced high when the table is split or adding.
  assign top_sel = din[LUT_K-1] | is_split | is_arith;

  flut4_mux_tree #(.SEL_W(LUT_K-1)) i_lo (
    .leaf_i(cfg_table[HALF_W-1:0]), .sel_i(half_sel), .y_o(lo_res));
  flut4_mux_tree #(.SEL_W(LUT_K-1)) i_hi (
    .leaf_i(cfg_table[TBL_W-1:HALF_W]), .sel_i(half_sel), .y_o(hi_res));

  assign lut3_o = {hi_res, lo_res};
  assign lut4_o = top_sel ? hi_res : lo_res;

  // Output selector.
  assign cell_o[0] = is_split ? lo_res : lut4_o;
  assign cell_o[1] = hi_res;

  flut4_carry_mux i_carry (
    .enable_i (is_arith),
    .prop_fn_i(cfg_table[3:0]),
    .gen_fn_i (cfg_table[7:4]),
    .sel_i    (din[1:0]),
    .carry_i  (carry_i),
    .carry_o  (carry_o)
  );
endmodule

// File: rtl/flut4_carry_cell_chk.sv
module flut4_carry_cell_chk (
  input logic [15:0] cfg_table,
  input logic [1:0]  cfg_mode,
  input logic [3:0]  din,
  input logic        carry_i,
  input logic        lut4_o,
  input logic [1:0]  lut3_o,
  input logic [1:0]  cell_o,
  input logic        carry_o
);
  always_comb begin
    if (cfg_mode == 2'b01) begin
      AST_SPLIT_TOP_HIGH: assert (lut4_o == lut3_o[1]); // R4
      AST_SPLIT_CELL0: assert (cell_o[0] == lut3_o[0]); // R8
    end
    if (cfg_mode != 2'b01) begin
      AST_CELL0_FOLLOWS: assert (cell_o[0] == lut4_o); // R8
    end
    AST_CELL1_WIRE: assert (cell_o[1] == lut3_o[1]); // R8
    if (cfg_mode != 2'b11) begin
      AST_CARRY_IDLE: assert (carry_o == 1'b0); // R7
    end
    if (cfg_mode == 2'b11 && cfg_table[{2'b00, din[1:0]}]) begin
      AST_CARRY_PROPAGATES: assert (carry_o == carry_i); // R6
    end
    if (cfg_mode == 2'b11) begin
      AST_ARITH_SUM_HALF: assert (lut4_o == lut3_o[1]); // R5
    end
  end
endmodule

bind flut4_carry_cell flut4_carry_cell_chk i_chk (
  .cfg_table(cfg_table), .cfg_mode(cfg_mode), .din(din), .carry_i(carry_i),
  .lut4_o(lut4_o), .lut3_o(lut3_o), .cell_o(cell_o), .carry_o(carry_o));

// File: tb/test_flut4_carry_cell.sv
module test_flut4_carry_cell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  logic [15:0] cfg_table;
  logic [1:0]  cfg_mode;
  logic [3:0]  din;
  logic        carry_i;
  logic        lut4_o;
  logic [1:0]  lut3_o;
  logic [1:0]  cell_o;
  logic        carry_o;

  flut4_carry_cell i_flut4_carry_cell (
    .cfg_table(cfg_table), .cfg_mode(cfg_mode), .din(din), .carry_i(carry_i),
    .lut4_o(lut4_o), .lut3_o(lut3_o), .cell_o(cell_o), .carry_o(carry_o));

  // Four-cell ripple chain
  logic [3:0] ch_a, ch_b, ch_hi;
  logic       ch_cin;
  logic [4:0] ch_c;
  logic [3:0] ch_sum;
  assign ch_c[0] = ch_cin;
  for (genvar i = 0; i < 4; i++) begin : g_chain
    logic [1:0] l3, co;
    flut4_carry_cell i_chain (
      .cfg_table(16'h9686), .cfg_mode(2'b11),
      .din({ch_hi[i], ch_hi[i], ch_b[i], ch_a[i]}), .carry_i(ch_c[i]),
      .lut4_o(ch_sum[i]), .lut3_o(l3), .cell_o(co), .carry_o(ch_c[i+1]));
  end

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (mode=%0d table=%h din=%b cin=%b)",
               tag, act, exp, cfg_mode, cfg_table, din, carry_i);
    end
  endtask

  function automatic int tbit(input logic [15:0] t, input int idx);
    return int'(t[idx]);
  endfunction

  task automatic apply(input logic [15:0] t, input logic [1:0] m,
                       input logic [3:0] d, input logic c);
    int lo_i, e4, e30, e31, ec;
    @(posedge clk); #1;
    cfg_table = t; cfg_mode = m; din = d; carry_i = c;
    @(negedge clk);
    if (m == 2'b11) lo_i = int'(c) * 4 + int'(d[1]) * 2 + int'(d[0]);
    else            lo_i = int'(d[2]) * 4 + int'(d[1]) * 2 + int'(d[0]);
    e30 = tbit(t, lo_i);
    e31 = tbit(t, 8 + lo_i);
    case (m)
      2'b01: e4 = e31;
      2'b11: e4 = e31;
      default: e4 = tbit(t, int'(d));
    endcase
    if (m == 2'b11)
      ec = tbit(t, int'(d[1:0])) ? int'(c) : tbit(t, 4 + int'(d[1:0]));
    else ec = 0;
    case (m)
      2'b00: check("R1 lut4", int'(lut4_o), e4);
      2'b10: check("R2 lut4", int'(lut4_o), e4);
      2'b01: begin
        check("R4 lut4", int'(lut4_o), e4);
        check("R3 lut3[0]", int'(lut3_o[0]), e30);
        check("R3 lut3[1]", int'(lut3_o[1]), e31);
      end
      default: check("R5 sum", int'(lut4_o), e4);
    endcase
    if (m != 2'b01) begin
      check("R9 lut3[0]", int'(lut3_o[0]), e30);
      check("R9 lut3[1]", int'(lut3_o[1]), e31);
    end
    if (m == 2'b11) check("R6 carry", int'(carry_o), ec);
    else            check("R7 carry", int'(carry_o), ec);
    check("R8 cell0", int'(cell_o[0]), (m == 2'b01) ? e30 : e4);
    check("R8 cell1", int'(cell_o[1]), e31);
  endtask

  initial begin
    #1_000_000; // watchdog: 50,000 cycles
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    cfg_table = '0; cfg_mode = '0; din = '0; carry_i = 1'b0;
    ch_a = '0; ch_b = '0; ch_hi = '0; ch_cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: all-zero configuration gives all-zero outputs (R1, R7)
    check("R1 idle lut4", int'(lut4_o), 0);
    check("R7 idle carry", int'(carry_o), 0);
    // Directed: all-ones table, carry must stay idle outside arithmetic (R7)
    for (int m = 0; m < 3; m++) apply(16'hFFFF, 2'(m), 4'hF, 1'b1);
    // Random sweep in every mode; unused inputs toggle freely (R5, R7)
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 200; k++)
        apply(16'($urandom), 2'(m), 4'($urandom), 1'($urandom));
    // Every input pattern against one fixed table per mode
    for (int m = 0; m < 4; m++)
      for (int v = 0; v < 32; v++)
        apply(16'hA5C3 ^ 16'(m * 16'h1111), 2'(m), 4'(v), 1'(v >> 4));
    // Ripple chain, exhaustive (R10)
    for (int v = 0; v < 512; v++) begin
      int s;
      @(posedge clk); #1;
      ch_a = 4'(v); ch_b = 4'(v >> 4); ch_cin = 1'(v >> 8); ch_hi = 4'($urandom);
      @(negedge clk);
      s = (v & 15) + ((v >> 4) & 15) + ((v >> 8) & 1);
      n_vec++;
      if ({ch_c[4], ch_sum} != 5'(s)) begin
        n_bad++;
        $display("FAIL R10 chain actual=%0d expected=%0d", {ch_c[4], ch_sum}, s);
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule